// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address for a four-beat memory burst. A load strobe captures a full external address. The two lowest bits of that address become the first beat of the burst, and the bits above them are held unchanged for the whole burst. After that, every clock on which the active-low advance strobe is low moves the low two bits to the next beat. When the strobe is high, the current beat is held, so a burst can be suspended for any number of cycles.

The `interleave_i` pin is a static mode select. When it is high, the beats follow an XOR-style interleaved order. When it is low, the low bits count upward and wrap within the aligned group of four. In both modes, an advance after the fourth beat returns to the first beat of the same group.

All ports are plain control and address pins. The block carries no data, so it has no valid/ready stream and no back-pressure. The caller gives each strobe for one cycle and may repeat it on any cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high `rst` drives `addr_o` to all zeros at the clock edge where `rst` is sampled high. This also applies in the middle of a burst.
- R2: With `interleave_i` = 1, the low two bits of `addr_o` go through these orders, by start value: from 00 the order is 00,01,10,11; from 01 it is 01,00,11,10; from 10 it is 10,11,00,01; from 11 it is 11,10,01,00.
- R3: With `interleave_i` = 0, the low two bits increase by one on each advance, modulo 4. For example, a start of 10 gives 10,11,00,01.
- R4: When `load_i` is high at a clock edge, `addr_o` equals `addr_i` after that edge, and the burst restarts at beat 0. Load takes priority over an advance in the same cycle.
- R5: The beat moves forward only at an edge where `adv_n_i` is low and `load_i` is low.
- R6: At an edge where `adv_n_i` is high and `load_i` is low, `addr_o` keeps its value (suspend).
- R7: An advance after the fourth beat returns `addr_o` to the first beat of the burst. The address never leaves the aligned group of four.
- R8: The bits of `addr_o` above bit 1 change only at a load or a reset. Changes on `addr_i` without `load_i` have no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start a new burst from `addr_i` |
| addr_i | input | ADDR_W | External burst start address |
| adv_n_i | input | 1 | Advance to the next beat, active low |
| interleave_i | input | 1 | 1 = interleaved order, 0 = linear order (static) |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench starts a burst from each of the four start values in both modes. It advances past the fourth beat, so a sequencer that carried into bit 2, or that stopped at beat 3, would give a wrong upper field or a stuck beat. It inserts suspend cycles and changes `addr_i` without a load, which would show an advance that ignored the strobe or upper bits that followed the input pins. It also asserts load and advance together and applies a reset in the middle of a burst. A design with the wrong priority would skip the first beat, and one with a reset that did not clear everything would keep a stale offset.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bas_beat_ctr.sv
// Counts beats within the burst. It clears on restart and wraps naturally.
module bas_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)          cnt_o <= '0;
    else if (restart) cnt_o <= '0;
    else if (step)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/bas_base_reg.sv
// Captures the start address. Upper field and start offset are kept apart.
module bas_base_reg #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [ADDR_W-1:BEAT_W]   upper_o,
  output logic [BEAT_W-1:0]        start_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      upper_o <= '0;
      start_o <= '0;
    end else if (load) begin
      upper_o <= addr_i[ADDR_W-1:BEAT_W];
      start_o <= addr_i[BEAT_W-1:0];
    end
  end
endmodule

// File: rtl/bas_order_map.sv
// Maps the start offset and beat count onto the burst offset for the selected order.
module bas_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic              [BEAT_W-1:0] start_i,
  input  logic              [BEAT_W-1:0] cnt_i,
  input  bas_pkg::order_e                mode_i,
  output logic              [BEAT_W-1:0] off_o
);
  logic [BEAT_W-1:0] xor_off;
  logic [BEAT_W-1:0] sum_off;

  genvar b;
  generate
    for (b = 0; b < BEAT_W; b++) begin : g_xor
      assign xor_off[b] = start_i[b] ^ cnt_i[b];
    end
  endgenerate

  assign sum_off = start_i + cnt_i;

  always_comb begin
    if (mode_i == bas_pkg::ORD_INTERLEAVE) off_o = xor_off;
    else                                   off_o = sum_off;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_n_i,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:BEAT_W] upper_q;
  logic [BEAT_W-1:0]      start_q;
  logic [BEAT_W-1:0]      cnt_q;
  logic [BEAT_W-1:0]      off;
  logic                   step;
  bas_pkg::order_e        mode;

  assign step = !load_i && !adv_n_i;
  assign mode = bas_pkg::order_e'(interleave_i);

  bas_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
    .clk(clk), .rst(rst), .load(load_i), .addr_i(addr_i),
    .upper_o(upper_q), .start_o(start_q)
  );

  bas_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk(clk), .rst(rst), .restart(load_i), .step(step), .cnt_o(cnt_q)
  );

  bas_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i(start_q), .cnt_i(cnt_q), .mode_i(mode), .off_o(off)
  );

  assign addr_o = {upper_q, off};
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              adv_n_i,
  input logic              interleave_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic [BEAT_W-1:0] low_inc;
  assign low_inc = addr_o[BEAT_W-1:0] + 1'b1;

  a_r4_load_captures: assert property (@(posedge clk) disable iff (rst)
    load_i |=> addr_o == $past(addr_i));

  a_r6_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> ($stable(addr_o) || !$stable(interleave_i)));

  a_r8_upper_steady: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && !interleave_i) |=>
      (interleave_i || addr_o[BEAT_W-1:0] == $past(low_inc)));

  a_r2_interleave_lsb_toggles: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && interleave_i) |=>
      (!interleave_i || addr_o[0] != $past(addr_o[0])));
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_bas_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .addr_i(addr_i),
  .adv_n_i(adv_n_i), .interleave_i(interleave_i), .addr_o(addr_o)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic [W-1:0] addr_i = '0;
  logic         adv_n_i = 1'b1;
  logic         interleave_i = 1'b1;
  logic [W-1:0] addr_o;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(W), .BEAT_W(2)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .load_i(load_i), .addr_i(addr_i),
    .adv_n_i(adv_n_i), .interleave_i(interleave_i), .addr_o(addr_o)
  );

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // reference model state
  logic [W-1:2] m_upper = '0;
  logic [1:0]   m_start = '0;
  int           m_beat  = 0;
  logic         m_il    = 1'b1;

  // R2 table written out; R3 as modulo-4 count
  function automatic logic [1:0] beat_off(input logic il, input logic [1:0] s, input int k);
    logic [1:0] il_tab [4][4];
    il_tab[0] = '{2'b00, 2'b01, 2'b10, 2'b11};
    il_tab[1] = '{2'b01, 2'b00, 2'b11, 2'b10};
    il_tab[2] = '{2'b10, 2'b11, 2'b00, 2'b01};
    il_tab[3] = '{2'b11, 2'b10, 2'b01, 2'b00};
    if (il) return il_tab[s][k];
    return 2'((int'(s) + k) % 4);
  endfunction

  task automatic push_exp(input string tag);
    exp_q.push_back({m_upper, beat_off(m_il, m_start, m_beat)});
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; load_i = 1'b0; adv_n_i = 1'b1;
    m_upper = '0; m_start = '0; m_beat = 0;
    push_exp(tag);
  endtask

  task automatic cyc(input logic ld, input logic [W-1:0] a, input logic advn, input string tag);
    @(negedge clk);
    rst = 1'b0; load_i = ld; addr_i = a; adv_n_i = advn; interleave_i = m_il;
    if (ld) begin
      m_upper = a[W-1:2]; m_start = a[1:0]; m_beat = 0;
    end else if (!advn) begin
      m_beat = (m_beat + 1) % 4;
    end
    push_exp(tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (addr_o !== e) begin
          fails++;
          $display("FAIL %s: addr_o=%h expected %h", t, addr_o, e);
        end
      end
    end
  end

  initial begin
    do_reset("R1");
    do_reset("R1");
    for (int mi = 0; mi < 2; mi++) begin
      m_il = (mi == 0);
      for (int s = 0; s < 4; s++) begin
        logic [W-1:0] base;
        string ord;
        ord  = m_il ? "R2" : "R3";
        base = {14'(16'h1A5C + s * 16'h0123), 2'(s)};
        cyc(1'b1, base, 1'b1, "R4");
        cyc(1'b0, base, 1'b0, ord);
        cyc(1'b0, base, 1'b1, "R6");
        cyc(1'b0, base, 1'b1, "R6");
        cyc(1'b0, base, 1'b0, ord);
        cyc(1'b0, 16'hFFFF ^ base, 1'b1, "R8");
        cyc(1'b0, 16'h0000, 1'b0, "R5");
        cyc(1'b0, base, 1'b0, "R7");
        cyc(1'b0, base, 1'b0, ord);
      end
      // load together with advance: load wins
      cyc(1'b1, 16'hC3B6, 1'b0, "R4");
      cyc(1'b0, 16'hC3B6, 1'b0, "R5");
      // restart mid-burst from a new address
      cyc(1'b1, 16'h0401, 1'b1, "R4");
      cyc(1'b0, 16'h0401, 1'b0, "R5");
      // reset mid-burst
      do_reset("R1");
      cyc(1'b0, 16'h7777, 1'b0, m_il ? "R2" : "R3");
    end
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule